// File: doc/BRIEF.md
# Dual Timer/Counter with 32-bit Cascade

This block holds two 16-bit timer/counters, timer 0 and timer 1. Each is stored as a low byte and a high byte. A small write/read register interface reaches a mode register, a control register and the four count bytes. Each timer counts either the shared prescaled internal tick or falling edges on its own external count pin. Each timer can also be gated by an external level pin.

Every count event arrives as a single-cycle enable. The internal tick is an input pulse, and the pins are sampled only in cycles where that tick is high. A carry out of a timer sets its overflow flag. The flag stays set until the matching acknowledge input is pulsed.

There are three ways to combine the timers. A control bit chains them into one 32-bit counter. Mode 3 on timer 0 splits it into two independent 8-bit counters. Mode 3 on timer 1 halts timer 1.

Top module: `dual_timer`

## Requirements
- R1: After reset, the mode register, the control register, all four count bytes, both overflow flags and both pin samples are 0.
- R2: Register addresses are 0 mode, 1 control, 2 timer 0 low, 3 timer 0 high, 4 timer 1 low and 5 timer 1 high. In the mode register, bits 3..0 configure timer 0 and bits 7..4 configure timer 1, each nibble as {gate, external, mode[1:0]} from MSB to LSB. In the control register, bit 0 is the timer 0 run bit, bit 1 is the timer 1 run bit and bit 2 is the cascade bit. Control bits 7..3 read back as 0.
- R3: Mode 0 is a 13-bit counter. Low-byte bits 4..0 act as a prescaler, and their wrap increments the high byte. Low-byte bits 7..5 are left unchanged. The overflow flag sets when all 13 bits wrap.
- R4: Mode 1 is a 16-bit counter over {high, low}. The overflow flag sets when the count wraps from FFFFh to 0000h.
- R5: Mode 2 increments the low byte. When the low byte is FFh, a count event loads the low byte from the high byte and sets the overflow flag.
- R6: With timer 0 in mode 3, the timer 0 low byte counts under the timer 0 controls, and its carry sets flag 0. The timer 0 high byte counts every internal tick while the timer 1 run bit is 1, and its carry sets flag 1.
- R7: With timer 1 in mode 3 and cascade off, the timer 1 bytes change only by software writes.
- R8: With the external bit at 0, a running timer counts every cycle in which the tick is high. With the external bit at 1, it counts on a tick in which the pin is 0 and the sample taken at the previous tick was 1. The pin is sampled on every tick, whether or not the timer runs.
- R9: With the gate bit at 1, a timer counts only while its run bit and its gate pin are both 1. With the gate bit at 0, the gate pin has no effect.
- R10: A flag sets in the cycle after its timer's carry. It clears in the cycle after its acknowledge input is high. A carry in the same cycle as an acknowledge leaves the flag set.
- R11: With cascade on, the four bytes form one 32-bit counter, with timer 0 low as the least significant byte. It counts under the timer 0 controls. A wrap of all 32 bits sets flag 1, and flag 0 is never set by counting.
- R12: A write to a count byte in the same cycle as a count event stores the written value in that byte. The other bytes take their counted values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle internal count enable; pins are sampled on it |
| cnt_pin | input | 2 | Synchronised external count pins, bit i for timer i |
| gate_pin | input | 2 | Synchronised gate pins, bit i for timer i |
| ovf_ack | input | 2 | Acknowledge pulses that clear the overflow flags |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| ovf | output | 2 | Overflow flags, bit i for timer i |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a carry and the acknowledge of the same flag. The second pair is a software write to a count byte and a count event that would change that byte.

Directed cases drive each pair deliberately. A counter is loaded to FFh or FFFFh, then the tick is pulsed together with the acknowledge or with the write. The expected outcome is that the flag stays set and the written byte keeps the written value, while the carry still reaches the neighbouring byte.

A seeded random phase biases written values toward FFh so that carries occur often. It pulses acknowledges and writes freely, so that both collisions recur under every mode, under gating and under cascade. Each cycle is compared with a bench reference model.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned PRE_W    = 5;
  localparam int unsigned N_BYTES  = 4;
  localparam int unsigned REG_MODE = 0;
  localparam int unsigned REG_CTRL = 1;
  localparam int unsigned REG_CNT0 = 2;

  typedef enum logic [1:0] {
    MODE_PRESC  = 2'd0,
    MODE_WIDE   = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } tmr_cfg_t;
endpackage

// File: rtl/dt_enable.sv
module dt_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic gate,
  input  logic ext,
  input  logic cnt_pin,
  input  logic gate_pin,
  output logic inc
);
  logic last_q;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= 1'b0;
    else if (tick) last_q <= cnt_pin;
  end

  assign fall = last_q & ~cnt_pin;
  assign inc  = tick & run & (~gate | gate_pin) & (~ext | fall);
endmodule

// File: rtl/dt_count.sv
module dt_count
  import dt_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned PW = PRE_W
) (
  input  logic [3:0][BW-1:0] cnt_i,
  input  tmr_mode_e          mode0,
  input  tmr_mode_e          mode1,
  input  logic               casc,
  input  logic [1:0]         inc,
  input  logic               split_inc,
  output logic [3:0][BW-1:0] cnt_o,
  output logic [1:0]         carry
);
  localparam int unsigned PAIR_W = 2 * BW + 1;
  localparam int unsigned FULL_W = 4 * BW + 1;

  function automatic logic [PAIR_W-1:0] step(tmr_mode_e m, logic [BW-1:0] lo, logic [BW-1:0] hi);
    logic [PAIR_W-1:0] r;
    logic [PW-1:0]     pre;
    r   = {1'b0, hi, lo};
    pre = lo[PW-1:0];
    case (m)
      MODE_PRESC: begin
        r[PW-1:0] = pre + 1'b1;
        if (&pre) begin
          r[2*BW-1:BW] = hi + 1'b1;
          r[2*BW]      = &hi;
        end
      end
      MODE_WIDE:   r = {1'b0, hi, lo} + PAIR_W'(1);
      MODE_RELOAD: r = (&lo) ? {1'b1, hi, hi} : {1'b0, hi, lo + 1'b1};
      default:     r = {1'b0, hi, lo};
    endcase
    return r;
  endfunction

  logic [PAIR_W-1:0] t0, t1;

  always_comb begin
    cnt_o = cnt_i;
    carry = '0;
    t0    = '0;
    t1    = '0;
    if (casc) begin
      if (inc[0]) {carry[1], cnt_o} = {1'b0, cnt_i} + FULL_W'(1);
    end else begin
      if (mode0 == MODE_SPLIT) begin
        if (inc[0])    {carry[0], cnt_o[0]} = {1'b0, cnt_i[0]} + (BW+1)'(1);
        if (split_inc) {carry[1], cnt_o[1]} = {1'b0, cnt_i[1]} + (BW+1)'(1);
      end else if (inc[0]) begin
        t0       = step(mode0, cnt_i[0], cnt_i[1]);
        carry[0] = t0[2*BW];
        cnt_o[1] = t0[2*BW-1:BW];
        cnt_o[0] = t0[BW-1:0];
      end
      if (mode1 != MODE_SPLIT && inc[1]) begin
        t1       = step(mode1, cnt_i[2], cnt_i[3]);
        carry[1] = carry[1] | t1[2*BW];
        cnt_o[3] = t1[2*BW-1:BW];
        cnt_o[2] = t1[BW-1:0];
      end
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dt_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic [1:0]        ovf_ack,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [1:0]        ovf
);
  localparam int unsigned BW     = BYTE_W;
  localparam int unsigned N_TMR  = 2;
  localparam logic [AW-1:0] A_MODE = AW'(REG_MODE);
  localparam logic [AW-1:0] A_CTRL = AW'(REG_CTRL);

  logic [BW-1:0]         mode_q;
  logic [N_TMR-1:0]      run_q;
  logic                  casc_q;
  logic [3:0][BW-1:0]    cnt_q, cnt_nx;
  logic [1:0]            ovf_q, carry;
  logic [N_TMR-1:0]      inc;
  tmr_cfg_t              cfg [N_TMR];
  logic                  t1_wr;

  always_comb begin
    for (int i = 0; i < N_TMR; i++) cfg[i] = tmr_cfg_t'(mode_q[4*i +: 4]);
  end

  generate
    for (genvar g = 0; g < N_TMR; g++) begin : g_en
      dt_enable u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (run_q[g]),
        .gate     (cfg[g].gate),
        .ext      (cfg[g].ext),
        .cnt_pin  (cnt_pin[g]),
        .gate_pin (gate_pin[g]),
        .inc      (inc[g])
      );
    end
  endgenerate

  dt_count #(.BW(BW), .PW(PRE_W)) u_cnt (
    .cnt_i     (cnt_q),
    .mode0     (cfg[0].mode),
    .mode1     (cfg[1].mode),
    .casc      (casc_q),
    .inc       (inc),
    .split_inc (tick & run_q[1]),
    .cnt_o     (cnt_nx),
    .carry     (carry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      casc_q <= 1'b0;
      cnt_q  <= '0;
      ovf_q  <= '0;
    end else begin
      cnt_q <= cnt_nx;
      for (int k = 0; k < N_BYTES; k++)
        if (wr_en && wr_addr == AW'(REG_CNT0 + k)) cnt_q[k] <= wr_data;
      if (wr_en && wr_addr == A_MODE) mode_q <= wr_data;
      if (wr_en && wr_addr == A_CTRL) begin
        run_q  <= wr_data[1:0];
        casc_q <= wr_data[2];
      end
      ovf_q <= carry | (ovf_q & ~ovf_ack);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_MODE)      rd_data = mode_q;
    else if (rd_addr == A_CTRL) rd_data = {{(BW-3){1'b0}}, casc_q, run_q};
    else
      for (int k = 0; k < N_BYTES; k++)
        if (rd_addr == AW'(REG_CNT0 + k)) rd_data = cnt_q[k];
  end

  assign ovf   = ovf_q;
  assign t1_wr = wr_en && (wr_addr == AW'(REG_CNT0 + 2) || wr_addr == AW'(REG_CNT0 + 3));

  AST_FLAG_SET_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    carry[0] |=> ovf[0]); // R10
  AST_FLAG_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ack[1] && !carry[1]) |=> !ovf[1]); // R10
  AST_SPLIT_T1_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc_q && cfg[1].mode == MODE_SPLIT && !t1_wr)
      |=> (cnt_q[2] == $past(cnt_q[2]) && cnt_q[3] == $past(cnt_q[3]))); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(REG_CNT0)) |=> cnt_q[0] == $past(wr_data)); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt_q)); // R8
  AST_CASC_NO_T0_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (casc_q && ovf_ack[0]) |=> !ovf[0]); // R11
endmodule

// File: tb/dual_timer_bench.sv
module dual_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] cnt_pin = '0, gate_pin = '0, ovf_ack = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] ovf;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_mode, m_cnt [4];
  logic [1:0] m_run, m_ovf, m_prev;
  logic       m_casc;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer u_dual_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .ovf_ack(ovf_ack), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ovf(ovf)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic clk1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rdchk(string tag, logic [2:0] a, logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    clk1();
    wr_en = 1'b0;
  endtask

  task automatic tk(int n);
    tick = 1'b1;
    repeat (n) clk1();
    tick = 1'b0;
  endtask

  task automatic tkp(logic p);
    cnt_pin[0] = p;
    tk(1);
  endtask

  // reference step of one timer for modes 0..2: {carry, hi, lo}
  function automatic logic [16:0] adv(logic [1:0] md, logic [7:0] lo, logic [7:0] hi);
    logic [13:0] w13;
    logic [16:0] w17;
    case (md)
      2'd0: begin
        w13 = {1'b0, hi, lo[4:0]} + 14'd1;
        return {w13[13], w13[12:5], lo[7:5], w13[4:0]};
      end
      2'd1: begin
        w17 = {1'b0, hi, lo} + 17'd1;
        return w17;
      end
      2'd2: return (lo == 8'hFF) ? {1'b1, hi, hi} : {1'b0, hi, lo + 8'd1};
      default: return {1'b0, hi, lo};
    endcase
  endfunction

  task automatic model_step();
    logic [1:0]  en;
    logic [1:0]  cy;
    logic [7:0]  nx [4];
    logic [32:0] w33;
    logic [16:0] r;
    cy = '0;
    for (int i = 0; i < 2; i++) begin
      en[i] = tick && m_run[i] && (!m_mode[4*i+3] || gate_pin[i]) &&
              (!m_mode[4*i+2] || (m_prev[i] && !cnt_pin[i]));
    end
    for (int k = 0; k < 4; k++) nx[k] = m_cnt[k];
    if (m_casc) begin
      if (en[0]) begin
        w33 = {1'b0, m_cnt[3], m_cnt[2], m_cnt[1], m_cnt[0]} + 33'd1;
        {cy[1], nx[3], nx[2], nx[1], nx[0]} = w33;
      end
    end else begin
      if (m_mode[1:0] == 2'd3) begin
        if (en[0]) begin cy[0] = (m_cnt[0] == 8'hFF); nx[0] = m_cnt[0] + 8'd1; end
        if (tick && m_run[1]) begin cy[1] = (m_cnt[1] == 8'hFF); nx[1] = m_cnt[1] + 8'd1; end
      end else if (en[0]) begin
        r = adv(m_mode[1:0], m_cnt[0], m_cnt[1]);
        cy[0] = r[16]; nx[1] = r[15:8]; nx[0] = r[7:0];
      end
      if (m_mode[5:4] != 2'd3 && en[1]) begin
        r = adv(m_mode[5:4], m_cnt[2], m_cnt[3]);
        cy[1] = cy[1] | r[16]; nx[3] = r[15:8]; nx[2] = r[7:0];
      end
    end
    if (wr_en) begin
      if (wr_addr == 3'd0) m_mode = wr_data;
      if (wr_addr == 3'd1) begin m_run = wr_data[1:0]; m_casc = wr_data[2]; end
      if (wr_addr >= 3'd2 && wr_addr <= 3'd5) nx[wr_addr - 3'd2] = wr_data;
    end
    for (int k = 0; k < 4; k++) m_cnt[k] = nx[k];
    m_ovf = cy | (m_ovf & ~ovf_ack);
    if (tick) m_prev = cnt_pin;
  endtask

  function automatic logic [7:0] model_rd(logic [2:0] a);
    if (a == 3'd0) return m_mode;
    if (a == 3'd1) return {5'd0, m_casc, m_run};
    if (a >= 3'd2 && a <= 3'd5) return m_cnt[a - 3'd2];
    return 8'h00;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 6; a++) rdchk("R1 reset reg", 3'(a), 8'h00);
    chk("R1 reset flags", {6'd0, ovf}, 8'h00);
    // R2 register map
    wr(3'd0, 8'hA5); rdchk("R2 mode readback", 3'd0, 8'hA5);
    wr(3'd1, 8'hFF); rdchk("R2 ctrl readback", 3'd1, 8'h07);
    wr(3'd1, 8'h00);
    // R3 mode 0, 13-bit wrap, upper low bits kept
    wr(3'd0, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    tk(1);
    rdchk("R3 low", 3'd2, 8'hE0); rdchk("R3 high", 3'd3, 8'h00);
    chk("R3 flag0", {7'd0, ovf[0]}, 8'h01);
    ovf_ack = 2'b01; clk1(); ovf_ack = 2'b00;
    chk("R10 ack clears", {6'd0, ovf}, 8'h00);
    // R4 mode 1
    wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'h12);
    tk(1);
    rdchk("R4 low", 3'd2, 8'h00); rdchk("R4 high", 3'd3, 8'h13);
    chk("R4 no flag", {6'd0, ovf}, 8'h00);
    // R5 mode 2 reload
    wr(3'd0, 8'h02); wr(3'd3, 8'h80); wr(3'd2, 8'hFF);
    tk(1);
    rdchk("R5 reload", 3'd2, 8'h80);
    chk("R5 flag0", {6'd0, ovf}, 8'h01);
    ovf_ack = 2'b01; clk1(); ovf_ack = 2'b00;
    // R10 carry and ack in the same cycle
    wr(3'd2, 8'hFF);
    tick = 1'b1; ovf_ack = 2'b01; clk1(); tick = 1'b0; ovf_ack = 2'b00;
    chk("R10 set beats ack", {6'd0, ovf}, 8'h01);
    ovf_ack = 2'b01; clk1(); ovf_ack = 2'b00;
    // R6 split mode
    wr(3'd0, 8'h03); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd1, 8'h03);
    tk(1);
    chk("R6 both flags", {6'd0, ovf}, 8'h03);
    rdchk("R6 low wrap", 3'd2, 8'h00);
    ovf_ack = 2'b11; clk1(); ovf_ack = 2'b00;
    wr(3'd1, 8'h02);
    tk(1);
    rdchk("R6 low held", 3'd2, 8'h00); rdchk("R6 high on run1", 3'd3, 8'h01);
    // R7 timer 1 halted in mode 3
    wr(3'd0, 8'h30); wr(3'd4, 8'h05); wr(3'd5, 8'h00);
    tk(3);
    rdchk("R7 low1 held", 3'd4, 8'h05); rdchk("R7 high1 held", 3'd5, 8'h00);
    // R8 external falling edges
    wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    tkp(1); tkp(1); tkp(0); tkp(0); tkp(1); tkp(0); tkp(1);
    cnt_pin[0] = 1'b0; clk1();
    tkp(0);
    rdchk("R8 edge count", 3'd2, 8'h03);
    // R9 gate
    wr(3'd0, 8'h09); wr(3'd2, 8'h00);
    gate_pin[0] = 1'b0; tk(3);
    rdchk("R9 gated off", 3'd2, 8'h00);
    gate_pin[0] = 1'b1; tk(2);
    rdchk("R9 gated on", 3'd2, 8'h02);
    wr(3'd1, 8'h00); tk(2);
    rdchk("R9 run off", 3'd2, 8'h02);
    // R11 cascade
    wr(3'd0, 8'h11);
    for (int a = 2; a < 6; a++) wr(3'(a), 8'hFF);
    wr(3'd1, 8'h05);
    tk(1);
    for (int a = 2; a < 6; a++) rdchk("R11 32-bit wrap", 3'(a), 8'h00);
    chk("R11 flag1 only", {6'd0, ovf}, 8'h02);
    ovf_ack = 2'b11; clk1(); ovf_ack = 2'b00;
    // R12 write beats count
    wr(3'd1, 8'h01); wr(3'd0, 8'h01); wr(3'd2, 8'h40);
    tick = 1'b1; wr(3'd2, 8'h07); tick = 1'b0;
    rdchk("R12 written low", 3'd2, 8'h07);
    wr(3'd2, 8'hFF); wr(3'd3, 8'h20);
    tick = 1'b1; wr(3'd3, 8'h55); tick = 1'b0;
    rdchk("R12 low counted", 3'd2, 8'h00); rdchk("R12 written high", 3'd3, 8'h55);

    // random phase against the reference model
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);
    for (int a = 2; a < 6; a++) wr(3'(a), 8'h00);
    cnt_pin = '0; tk(1);
    ovf_ack = 2'b11; clk1(); ovf_ack = 2'b00;
    m_mode = '0; m_run = '0; m_casc = 1'b0; m_ovf = '0; m_prev = '0;
    for (int k = 0; k < 4; k++) m_cnt[k] = '0;
    for (int n = 0; n < 4000; n++) begin
      rd_addr = 3'($urandom_range(0, 5));
      #1;
      chk("MODEL reg", rd_data, model_rd(rd_addr));
      chk("MODEL flags", {6'd0, ovf}, {6'd0, m_ovf});
      wr_en    = ($urandom_range(0, 7) == 0);
      wr_addr  = 3'($urandom_range(0, 5));
      wr_data  = ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom);
      if (wr_addr == 3'd1) wr_data = 8'($urandom_range(0, 7));
      tick     = ($urandom_range(0, 1) == 1);
      cnt_pin  = 2'($urandom);
      gate_pin = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b11;
      ovf_ack  = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
      model_step();
      clk1();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule